// File: doc/BRIEF.md
# Vector result output modifier

This combinational stage conditions a 128-bit SIMD result on its way to register writeback. It receives the raw lane results, the element size, a 2-bit modifier code, a flag that says whether that code is read as a float or an integer modifier, a shrink selector and an 8-bit write mask. It returns the conditioned 128-bit value and a 16-bit byte-enable vector for the register file.

Float codes clamp fp32 or fp16 lanes to a fixed range and replace NaN with a constant that depends on the code. Integer codes act only while narrowing. Each lane is cut to half its width, either by saturation or by taking its low or high half. The narrowed lanes are packed into the lower or upper 64-bit half of the destination, and the other half is left unwritten.

Internally one select step picks one of four paths: PASS (the value is unchanged), F32 (fp32 clamp), F16 (fp16 clamp) or NARROW (integer narrowing). The path is chosen from the modifier kind, the element size and the shrink selector. The choice is made afresh for every input and holds no state.

Top module: `vec_result_conditioner`

## Requirements
- R1: With the float kind (`mod_is_int_i`=0) and code 0, `data_o` equals `raw_i`.
- R2: Float code 1 applies max(x, 0.0) per lane. A NaN or any negative nonzero value becomes +0.0. A -0.0 input is returned unchanged.
- R3: Float code 2 clamps each lane to [-1.0, 1.0], keeping the sign. A NaN becomes -1.0, which is 0xBF800000 for fp32 and 0xBC00 for fp16.
- R4: Float code 3 clamps each lane to [0.0, 1.0]. A NaN or a negative nonzero value becomes +0.0, a value above 1.0 becomes 1.0, and -0.0 is returned unchanged.
- R5: Element size is encoded 0=8, 1=16, 2=32, 3=64 bits. The float modifiers act on sizes 2 (fp32) and 1 (fp16); for sizes 0 and 3 the data passes unchanged. The float path ignores the shrink selector.
- R6: With the integer kind and shrink selector 2 (no shrink) or 3 (treated as 2), `data_o` equals `raw_i` for every integer code.
- R7: With the integer kind, shrink selector 0 (lower) or 1 (upper), and element size W of 16, 32 or 64 bits, narrowed lane i of width W/2 is placed at bit `base + i*W/2`. The base is 0 for lower and 64 for upper. The other half of `data_o` is zero.
- R8: Integer code 0 (signed saturate) clamps the signed lane value to [-2^(n-1), 2^(n-1)-1], where n = W/2.
- R9: Integer code 1 (unsigned saturate) reads the lane as signed, maps negative values to 0, and clamps values above 2^n-1 to 2^n-1.
- R10: Integer code 2 keeps the low n bits of the lane, and code 3 keeps the high n bits.
- R11: Write-mask bit k enables bytes 2k and 2k+1 of `byte_en_o`. While narrowing, every byte of the 64-bit half that is not written is disabled.
- R12: With the integer kind and element size 0, shrink selectors 0 and 1 narrow nothing. The data passes unchanged and all mask-enabled bytes stay enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| raw_i | input | 128 | Raw lane results |
| elem_size_i | input | 2 | Element size code (0=8, 1=16, 2=32, 3=64 bits) |
| mod_code_i | input | 2 | Output modifier code |
| mod_is_int_i | input | 1 | 1: code is an integer modifier, 0: float modifier |
| shrink_sel_i | input | 2 | 0 lower half, 1 upper half, 2/3 no shrink |
| wmask_i | input | 8 | Write mask, one bit per 16-bit slice |
| data_o | output | 128 | Conditioned result |
| byte_en_o | output | 16 | Byte enables for writeback |

## Verification
The hardest situations to reach are the values that sit exactly on a clamp boundary. These are the neighbours of ±1.0 in both float formats, -0.0, the infinities, quiet and signalling NaNs, and integers one step inside or outside the half-width range. Random 32- or 64-bit values almost never land on them. The fp16 lanes and the 16-to-8-bit narrowing are swept over all 65536 input patterns, eight lanes per vector, so every boundary in those formats is covered. The wider formats use a list of edge values plus random values that are arithmetically shifted by a random amount, which places many of them near the saturation limits.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    localparam int unsigned VEC_W   = 128;
    localparam int unsigned HALF_W  = VEC_W / 2;
    localparam int unsigned SLICE_W = 16;
    localparam int unsigned N_SLICE = VEC_W / SLICE_W;
    localparam int unsigned N_BYTE  = VEC_W / 8;
    localparam int unsigned HALF_BY = HALF_W / 8;

    typedef enum logic [1:0] {SZ_B8, SZ_B16, SZ_B32, SZ_B64} elem_size_e;
    typedef enum logic [1:0] {FM_NONE, FM_POS, FM_SNORM, FM_UNORM} fmod_e;
    typedef enum logic [1:0] {IM_SSAT, IM_USAT, IM_LOW, IM_HIGH} imod_e;
    typedef enum logic [1:0] {SH_LOWER, SH_UPPER, SH_NONE, SH_RSVD} shrink_e;
    typedef enum logic [1:0] {PATH_PASS, PATH_F32, PATH_F16, PATH_NARROW} path_e;
endpackage

// File: rtl/vrc_float_lane.sv
module vrc_float_lane import vrc_pkg::*; #(
    parameter int unsigned EW = 8,
    parameter int unsigned MW = 23
) (
    input  logic [EW+MW:0] x_i,
    input  logic [1:0]     code_i,
    output logic [EW+MW:0] y_o
);
    localparam int unsigned W = EW + MW + 1;
    localparam logic [W-1:0] ONE     = {2'b00, {(EW-1){1'b1}}, {MW{1'b0}}};
    localparam logic [W-1:0] NEG_ONE = {1'b1, ONE[W-2:0]};

    logic is_nan, neg_nz, above_one;

    always_comb begin
        is_nan    = (&x_i[W-2:MW]) && (|x_i[MW-1:0]);
        neg_nz    = x_i[W-1] && (|x_i[W-2:0]);
        above_one = x_i[W-2:0] > ONE[W-2:0];
    end

    always_comb begin
        unique case (fmod_e'(code_i))
            FM_NONE:  y_o = x_i;
            FM_POS:   y_o = (is_nan || neg_nz) ? '0 : x_i;
            FM_SNORM: begin
                if (is_nan)         y_o = NEG_ONE;
                else if (above_one) y_o = x_i[W-1] ? NEG_ONE : ONE;
                else                y_o = x_i;
            end
            FM_UNORM: begin
                if (is_nan || neg_nz) y_o = '0;
                else if (above_one)   y_o = ONE;
                else                  y_o = x_i;
            end
            default: y_o = x_i;
        endcase
    end

    always_comb begin
        if (code_i != 2'd0)
            a_r2_no_nan_out: assert (!((&y_o[W-2:MW]) && (|y_o[MW-1:0])))
                else $error("clamped lane still NaN");
        if (code_i == 2'd2)
            a_r3_unit_range: assert (y_o[W-2:0] <= ONE[W-2:0])
                else $error("snorm lane out of range");
        if (code_i == 2'd1 || code_i == 2'd3)
            a_r4_non_negative: assert (!y_o[W-1] || y_o[W-2:0] == '0)
                else $error("non-negative clamp produced negative");
    end
endmodule

// File: rtl/vrc_float_group.sv
module vrc_float_group import vrc_pkg::*; #(
    parameter int unsigned EW = 8,
    parameter int unsigned MW = 23
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [1:0]       code_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam int unsigned LW = EW + MW + 1;
    localparam int unsigned NL = VEC_W / LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        vrc_float_lane #(.EW(EW), .MW(MW)) u_lane (
            .x_i    (vec_i[i*LW +: LW]),
            .code_i (code_i),
            .y_o    (vec_o[i*LW +: LW])
        );
    end
endmodule

// File: rtl/vrc_narrow_lane.sv
module vrc_narrow_lane import vrc_pkg::*; #(
    parameter int unsigned IW = 16
) (
    input  logic [IW-1:0]   x_i,
    input  logic [1:0]      code_i,
    output logic [IW/2-1:0] y_o
);
    localparam int unsigned N = IW / 2;

    logic sign, fits_s, fits_u;

    always_comb begin
        sign   = x_i[IW-1];
        fits_s = (&x_i[IW-1:N-1]) || !(|x_i[IW-1:N-1]);
        fits_u = !(|x_i[IW-1:N]);
    end

    always_comb begin
        unique case (imod_e'(code_i))
            IM_SSAT: begin
                if (fits_s)    y_o = x_i[N-1:0];
                else if (sign) y_o = {1'b1, {(N-1){1'b0}}};
                else           y_o = {1'b0, {(N-1){1'b1}}};
            end
            IM_USAT: begin
                if (sign)        y_o = '0;
                else if (fits_u) y_o = x_i[N-1:0];
                else             y_o = '1;
            end
            IM_LOW:  y_o = x_i[N-1:0];
            IM_HIGH: y_o = x_i[IW-1:N];
            default: y_o = x_i[N-1:0];
        endcase
    end

    always_comb begin
        if (code_i == 2'd0)
            a_r8_sign_kept: assert (y_o[N-1] == x_i[IW-1])
                else $error("signed saturation flipped sign");
    end
endmodule

// File: rtl/vrc_narrow_group.sv
module vrc_narrow_group import vrc_pkg::*; #(
    parameter int unsigned IW = 16
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [1:0]        code_i,
    output logic [HALF_W-1:0] half_o
);
    localparam int unsigned NL = VEC_W / IW;
    localparam int unsigned N  = IW / 2;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        vrc_narrow_lane #(.IW(IW)) u_lane (
            .x_i    (vec_i[i*IW +: IW]),
            .code_i (code_i),
            .y_o    (half_o[i*N +: N])
        );
    end
endmodule

// File: rtl/vrc_byte_enable.sv
module vrc_byte_enable import vrc_pkg::*; (
    input  logic [N_SLICE-1:0] wmask_i,
    input  logic [1:0]         half_en_i,
    output logic [N_BYTE-1:0]  byte_en_o
);
    localparam int unsigned BY_PER_SLICE = SLICE_W / 8;

    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
        assign byte_en_o[b] = wmask_i[b / BY_PER_SLICE] & half_en_i[b / HALF_BY];
    end
endmodule

// File: rtl/vec_result_conditioner.sv
module vec_result_conditioner import vrc_pkg::*; (
    input  logic [127:0] raw_i,
    input  logic [1:0]   elem_size_i,
    input  logic [1:0]   mod_code_i,
    input  logic         mod_is_int_i,
    input  logic [1:0]   shrink_sel_i,
    input  logic [7:0]   wmask_i,
    output logic [127:0] data_o,
    output logic [15:0]  byte_en_o
);
    path_e             path;
    logic [VEC_W-1:0]  f32_out, f16_out;
    logic [HALF_W-1:0] nar [3];
    logic [HALF_W-1:0] nar_sel;
    logic [1:0]        half_en;
    logic              shrinking;

    vrc_float_group #(.EW(8), .MW(23)) u_f32 (
        .vec_i (raw_i), .code_i (mod_code_i), .vec_o (f32_out)
    );
    vrc_float_group #(.EW(5), .MW(10)) u_f16 (
        .vec_i (raw_i), .code_i (mod_code_i), .vec_o (f16_out)
    );

    for (genvar g = 0; g < 3; g++) begin : g_narrow
        vrc_narrow_group #(.IW(16 << g)) u_grp (
            .vec_i (raw_i), .code_i (mod_code_i), .half_o (nar[g])
        );
    end

    // path select
    always_comb begin
        shrinking = (shrink_e'(shrink_sel_i) == SH_LOWER) ||
                    (shrink_e'(shrink_sel_i) == SH_UPPER);
        path = PATH_PASS;
        if (!mod_is_int_i) begin
            unique case (elem_size_e'(elem_size_i))
                SZ_B32:  path = PATH_F32;
                SZ_B16:  path = PATH_F16;
                default: path = PATH_PASS;
            endcase
        end else if (shrinking && elem_size_e'(elem_size_i) != SZ_B8) begin
            path = PATH_NARROW;
        end
    end

    // outputs
    always_comb begin
        unique case (elem_size_e'(elem_size_i))
            SZ_B16:  nar_sel = nar[0];
            SZ_B32:  nar_sel = nar[1];
            default: nar_sel = nar[2];
        endcase
        half_en = 2'b11;
        unique case (path)
            PATH_PASS: data_o = raw_i;
            PATH_F32:  data_o = f32_out;
            PATH_F16:  data_o = f16_out;
            PATH_NARROW: begin
                if (shrink_sel_i[0]) begin
                    data_o  = {nar_sel, {HALF_W{1'b0}}};
                    half_en = 2'b10;
                end else begin
                    data_o  = {{HALF_W{1'b0}}, nar_sel};
                    half_en = 2'b01;
                end
            end
            default: data_o = raw_i;
        endcase
    end

    vrc_byte_enable u_be (
        .wmask_i   (wmask_i),
        .half_en_i (half_en),
        .byte_en_o (byte_en_o)
    );

    always_comb begin
        for (int b = 0; b < N_BYTE; b++) begin
            if (path == PATH_NARROW && (b / HALF_BY) != int'(shrink_sel_i[0]))
                a_r7_idle_half: assert (byte_en_o[b] == 1'b0 && data_o[b*8 +: 8] == 8'h00)
                    else $error("unwritten half carries data or enable");
        end
    end
endmodule

// File: tb/tb_vec_result_conditioner.sv
module tb_vec_result_conditioner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [127:0] raw_i;
    logic [1:0]   elem_size_i, mod_code_i, shrink_sel_i;
    logic         mod_is_int_i;
    logic [7:0]   wmask_i;
    logic [127:0] data_o;
    logic [15:0]  byte_en_o;

    vec_result_conditioner dut (
        .raw_i(raw_i), .elem_size_i(elem_size_i), .mod_code_i(mod_code_i),
        .mod_is_int_i(mod_is_int_i), .shrink_sel_i(shrink_sel_i),
        .wmask_i(wmask_i), .data_o(data_o), .byte_en_o(byte_en_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    longint unsigned rs = 64'h9E37_79B9_7F4A_7C15;

    function automatic longint unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    function automatic longint unsigned getf(logic [127:0] v, int lo, int w);
        longint unsigned r = 0;
        for (int b = 0; b < w; b++) r[b] = v[lo + b];
        return r;
    endfunction

    function automatic real fval(longint unsigned bits, int ew, int mw);
        int bias = (1 << (ew - 1)) - 1;
        longint unsigned m = bits & ((64'd1 << mw) - 1);
        int e = int'((bits >> mw) & ((64'd1 << ew) - 1));
        real mag;
        if (e == (1 << ew) - 1)  mag = 1.0e300;
        else if (e == 0)         mag = real'(m) * 2.0 ** real'(1 - bias - mw);
        else                     mag = (real'(m) + 2.0 ** real'(mw)) * 2.0 ** real'(e - bias - mw);
        return bits[ew + mw] ? -mag : mag;
    endfunction

    function automatic longint unsigned fref(longint unsigned x, int ew, int mw, int code);
        longint unsigned one  = ((64'd1 << (ew - 1)) - 1) << mw;
        longint unsigned none = one | (64'd1 << (ew + mw));
        longint unsigned em   = (64'd1 << ew) - 1;
        bit nan = (((x >> mw) & em) == em) && ((x & ((64'd1 << mw) - 1)) != 0);
        real v = fval(x, ew, mw);
        case (code)
            1: return (nan || v < 0.0) ? 0 : x;
            2: return nan ? none : (v > 1.0) ? one : (v < -1.0) ? none : x;
            3: return (nan || v < 0.0) ? 0 : (v > 1.0) ? one : x;
            default: return x;
        endcase
    endfunction

    function automatic longint unsigned nref(longint unsigned bits, int iw, int code);
        int n = iw / 2;
        longint unsigned mk = (64'd1 << n) - 1;
        longint v, r, maxp, minn;
        if (iw == 64) v = signed'(bits);
        else begin
            v = longint'(bits & ((64'd1 << iw) - 1));
            if (bits[iw - 1]) v = v - (longint'(1) << iw);
        end
        maxp = (longint'(1) << (n - 1)) - 1;
        minn = -(longint'(1) << (n - 1));
        case (code)
            0: r = (v > maxp) ? maxp : (v < minn) ? minn : v;
            1: r = (v < 0) ? 0 : (v > longint'(mk)) ? longint'(mk) : v;
            2: r = v;
            default: r = v >>> n;
        endcase
        return longint'(r) & mk;
    endfunction

    task automatic run(input logic [127:0] raw, input int sz, input int code,
                       input bit isint, input int shr, input logic [7:0] mask,
                       input string req);
        logic [127:0] ed;
        logic [15:0]  eb;
        bit lo_ok = 1, hi_ok = 1;
        @(negedge clk);
        raw_i = raw; elem_size_i = 2'(sz); mod_code_i = 2'(code);
        mod_is_int_i = isint; shrink_sel_i = 2'(shr); wmask_i = mask;
        #1;
        ed = raw;
        if (!isint) begin
            if (sz == 2) for (int i = 0; i < 4; i++) begin
                longint unsigned r = fref(getf(raw, i*32, 32), 8, 23, code);
                for (int b = 0; b < 32; b++) ed[i*32 + b] = r[b];
            end
            if (sz == 1) for (int i = 0; i < 8; i++) begin
                longint unsigned r = fref(getf(raw, i*16, 16), 5, 10, code);
                for (int b = 0; b < 16; b++) ed[i*16 + b] = r[b];
            end
        end else if ((shr == 0 || shr == 1) && sz != 0) begin
            int iw = 8 << sz;
            int n  = iw / 2;
            int base = shr * 64;
            ed = '0;
            lo_ok = (shr == 0); hi_ok = (shr == 1);
            for (int i = 0; i < 128 / iw; i++) begin
                longint unsigned r = nref(getf(raw, i*iw, iw), iw, code);
                for (int b = 0; b < n; b++) ed[base + i*n + b] = r[b];
            end
        end
        for (int b = 0; b < 16; b++) eb[b] = mask[b/2] && ((b < 8) ? lo_ok : hi_ok);
        n_checks++;
        if (data_o !== ed || byte_en_o !== eb) begin
            n_fail++;
            $display("FAIL %s: data=%h be=%h expected data=%h be=%h", req, data_o, byte_en_o, ed, eb);
        end
    endtask

    function automatic string freq(int code);
        case (code) 0: return "R1"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
    endfunction
    function automatic string ireq(int code);
        case (code) 0: return "R8"; 1: return "R9"; default: return "R10"; endcase
    endfunction

    longint unsigned e32 [13] = '{64'h0, 64'h80000000, 64'h3F800000, 64'hBF800000,
        64'h3F800001, 64'hBF800001, 64'h7F800000, 64'hFF800000, 64'h7FC00000,
        64'hFFC00001, 64'h3F7FFFFF, 64'h00000001, 64'h80000001};

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        raw_i = '0; elem_size_i = 0; mod_code_i = 0; mod_is_int_i = 0;
        shrink_sel_i = 0; wmask_i = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state: zero in, zero out, no enables (R11)
        run('0, 0, 0, 0, 2, 8'h00, "R11 idle");
        // fp16 exhaustive, shrink ignored (R1-R5)
        for (int code = 0; code < 4; code++)
            for (int k = 0; k < 8192; k++) begin
                logic [127:0] v;
                for (int j = 0; j < 8; j++) v[j*16 +: 16] = 16'(k*8 + j);
                run(v, 1, code, 0, int'(rnd() % 4), 8'(rnd()), {freq(code), " fp16 R5"});
            end
        // fp32 edges then random
        for (int code = 0; code < 4; code++)
            for (int k = 0; k < 1500; k++) begin
                logic [127:0] v;
                for (int j = 0; j < 4; j++)
                    v[j*32 +: 32] = (k < 13) ? 32'(e32[(k + j) % 13]) : 32'(rnd());
                run(v, 2, code, 0, int'(rnd() % 4), 8'(rnd()), {freq(code), " fp32"});
            end
        // float code on 8/64-bit sizes passes through (R5)
        for (int k = 0; k < 100; k++)
            run({rnd(), rnd()}, (k % 2) * 3, 1 + k % 3, 0, k % 4, 8'(rnd()), "R5 size");
        // 16->8 narrowing exhaustive, both halves (R7-R11)
        for (int code = 0; code < 4; code++)
            for (int k = 0; k < 8192; k++) begin
                logic [127:0] v;
                for (int j = 0; j < 8; j++) v[j*16 +: 16] = 16'(k*8 + j);
                run(v, 1, code, 1, k % 2, 8'(rnd()), {ireq(code), " R7 R11 n16"});
            end
        // 32->16 and 64->32 narrowing near the limits
        for (int sz = 2; sz < 4; sz++)
            for (int code = 0; code < 4; code++)
                for (int k = 0; k < 1500; k++) begin
                    logic [127:0] v;
                    for (int j = 0; j < 2; j++) begin
                        longint signed t = signed'(rnd());
                        v[j*64 +: 64] = 64'(t >>> (rnd() % 64));
                    end
                    run(v, sz, code, 1, int'(rnd() % 2), 8'(rnd()), {ireq(code), " R7 wide"});
                end
        // no shrink: any integer code leaves data unchanged (R6)
        for (int k = 0; k < 500; k++)
            run({rnd(), rnd()}, k % 4, (k / 4) % 4, 1, 2 + k % 2, 8'(rnd()), "R6");
        // 8-bit elements never narrow (R12)
        for (int k = 0; k < 200; k++)
            run({rnd(), rnd()}, 0, k % 4, 1, k % 2, 8'(rnd()), "R12");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule